// File: doc/BRIEF.md
# Frame and Multiframe Sync Generator

This block divides a synthesized source clock down to a frame-rate sync pulse (nominally 8 kHz) and a multiframe-rate sync pulse (nominally 2 kHz). Both outputs are registered on the source clock, so every transition lands on a clock edge. The multiframe pulse is locked to the frame pulse: it appears together with every fourth frame pulse and has the same width.

The frame period is set in source clock cycles by a divide value, for example 2430 to get 8 kHz from 19.44 MHz. The pulse width is set in source clock cycles. A single polarity bit inverts both outputs. An optional disciplining input lets an external sync signal realign the internal counters. It is set to either the frame rate, where only the frame phase is restarted, or the multiframe rate, where both the frame and the multiframe phase are restarted.

Top module: `sync_pulse_gen`

## Requirements
- R1: With no realignment, the frame output goes active in the cycle that follows the first rising clock edge with `rst` low. After that it goes active every D cycles, where D is the effective divide value.
- R2: The multiframe output is active only while the frame output is active. It is active on the first frame pulse after reset and on every fourth frame pulse after that, with the same width as the frame pulse.
- R3: Each pulse stays active for W consecutive cycles. W is `cfg_width`, except that a value of 0 counts as 1 and a value of D or more is clamped to D-1.
- R4: With `cfg_pol`=0 the outputs are active-high and idle low. With `cfg_pol`=1 both outputs are inverted: active-low and idle high.
- R5: While `rst` is high on a clock edge, both outputs are driven to the inactive level on that edge, and the frame and multiframe phases restart from zero.
- R6: With `disc_en`=1 and `disc_rate`=0 (frame-rate discipline), a rising edge on `sync_in` restarts the frame phase. The edge is defined as `sync_in` sampled low at one clock edge and high at the next, edge k. The frame pulse then begins in the cycle after edge k+1. The multiframe counter advances by one, as it does at any frame boundary.
- R7: With `disc_en`=1 and `disc_rate`=1 (multiframe-rate discipline), a rising edge on `sync_in` sampled at edge k restarts both phases. Both the frame pulse and the multiframe pulse then begin in the cycle after edge k+1.
- R8: With `disc_en`=0, `sync_in` has no effect on either output.
- R9: A `cfg_div` value below 2 is treated as 2, so D is never smaller than 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_div | input | CNT_W | Frame period in source clock cycles |
| cfg_width | input | WID_W | Pulse width in source clock cycles |
| cfg_pol | input | 1 | 0 = active-high outputs, 1 = active-low outputs |
| disc_en | input | 1 | Enables realignment from `sync_in` |
| disc_rate | input | 1 | 0 = `sync_in` is frame rate, 1 = `sync_in` is multiframe rate |
| sync_in | input | 1 | External sync, synchronous to `clk` |
| fsync_o | output | 1 | Frame sync pulse |
| mfsync_o | output | 1 | Multiframe sync pulse |

## Verification
The assertions assume that `sync_in` is already synchronous to the source clock. They also assume that `cfg_pol` is held steady across the reset cycles whose idle level they check, and that the divide and polarity settings change only at quiet points. The stimulus follows these assumptions. It changes configuration only between test phases. It drives `sync_in` from the same clock, as single-cycle pulses at phases that deliberately disagree with the free-running counters. It issues a fresh reset whenever the polarity changes, so every checked cycle has a well-defined expected level.

// File: rtl/sync_gen_pkg.sv
package sync_gen_pkg;

    localparam int MF_LEN = 4;
    localparam int MF_W   = $clog2(MF_LEN);

    typedef enum logic {
        DISC_FRAME = 1'b0,
        DISC_MULTI = 1'b1
    } disc_rate_e;

    typedef struct packed {
        logic multi;
        logic frame;
    } pulse_pair_t;

    function automatic logic [MF_W-1:0] mf_step(input logic [MF_W-1:0] m);
        return (int'(m) == MF_LEN - 1) ? '0 : m + 1'b1;
    endfunction

endpackage

// File: rtl/sgen_edge_det.sv
module sgen_edge_det (
    input  logic clk,
    input  logic rst,
    input  logic sync_in,
    output logic rise_o
);
    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= sync_in;
    end

    assign rise_o = sync_in & ~prev_q;

endmodule

// File: rtl/sgen_counters.sv
module sgen_counters
    import sync_gen_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] div_eff,
    input  logic             realign,
    input  logic             realign_mf,
    output logic [CNT_W-1:0] fcnt_o,
    output logic [MF_W-1:0]  mcnt_o
);
    logic [CNT_W-1:0] fcnt_q;
    logic [MF_W-1:0]  mcnt_q;
    logic             at_end;

    assign at_end = (fcnt_q >= div_eff - 1'b1);

    always_ff @(posedge clk) begin
        if (rst) begin
            fcnt_q <= '0;
            mcnt_q <= '0;
        end else if (realign) begin
            fcnt_q <= '0;
            mcnt_q <= realign_mf ? '0 : mf_step(mcnt_q);
        end else if (at_end) begin
            fcnt_q <= '0;
            mcnt_q <= mf_step(mcnt_q);
        end else begin
            fcnt_q <= fcnt_q + 1'b1;
        end
    end

    assign fcnt_o = fcnt_q;
    assign mcnt_o = mcnt_q;

    // R1: the frame phase always restarts after its last cycle
    p_frame_wrap_r1: assert property (@(posedge clk) disable iff (rst)
        at_end |=> (fcnt_q == '0));

    // R2: the multiframe phase rolls over after its fourth frame
    p_mf_roll_r2: assert property (@(posedge clk) disable iff (rst)
        (at_end && !realign && int'(mcnt_q) == MF_LEN - 1) |=> (mcnt_q == '0));

    // R6: frame-rate realignment keeps the multiframe moving
    p_realign_frame_r6: assert property (@(posedge clk) disable iff (rst)
        (realign && !realign_mf) |=> (fcnt_q == '0 && mcnt_q != $past(mcnt_q)));

    // R7: multiframe-rate realignment restarts both phases
    p_realign_multi_r7: assert property (@(posedge clk) disable iff (rst)
        (realign && realign_mf) |=> (fcnt_q == '0 && mcnt_q == '0));

endmodule

// File: rtl/sgen_shaper.sv
module sgen_shaper
    import sync_gen_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pol,
    input  logic [CNT_W-1:0] width_eff,
    input  logic [CNT_W-1:0] fcnt,
    input  logic [MF_W-1:0]  mcnt,
    output logic             fsync_o,
    output logic             mfsync_o
);
    localparam int N_OUT = 2;

    pulse_pair_t       act;
    logic [N_OUT-1:0]  act_v;
    logic [N_OUT-1:0]  out_q;

    always_comb begin
        act.frame = (fcnt < width_eff);
        act.multi = act.frame && (mcnt == '0);
        act_v     = {act.multi, act.frame};
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < N_OUT; i++) begin
            if (rst) out_q[i] <= pol;
            else     out_q[i] <= act_v[i] ^ pol;
        end
    end

    assign fsync_o  = out_q[0];
    assign mfsync_o = out_q[1];

    // R2: multiframe active implies frame active
    p_mf_inside_frame_r2: assert property (@(posedge clk) disable iff (rst)
        (mfsync_o != pol) |-> (fsync_o != pol));

    // R5: reset forces the idle level on both outputs
    p_idle_in_reset_r5: assert property (@(posedge clk)
        rst |=> (fsync_o == $past(pol) && mfsync_o == $past(pol)));

endmodule

// File: rtl/sync_pulse_gen.sv
module sync_pulse_gen
    import sync_gen_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int WID_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] cfg_div,
    input  logic [WID_W-1:0] cfg_width,
    input  logic             cfg_pol,
    input  logic             disc_en,
    input  logic             disc_rate,
    input  logic             sync_in,
    output logic             fsync_o,
    output logic             mfsync_o
);
    localparam logic [CNT_W-1:0] MIN_DIV = CNT_W'(2);

    logic [CNT_W-1:0] div_eff;
    logic [CNT_W-1:0] width_ext;
    logic [CNT_W-1:0] width_eff;
    logic             rise;
    logic             realign;
    logic             realign_mf;
    logic [CNT_W-1:0] fcnt;
    logic [MF_W-1:0]  mcnt;

    // R9 and R3: effective period and clamped width
    always_comb begin
        div_eff   = (cfg_div < MIN_DIV) ? MIN_DIV : cfg_div;
        width_ext = CNT_W'(cfg_width);
        if (width_ext == '0)          width_eff = CNT_W'(1);
        else if (width_ext >= div_eff) width_eff = div_eff - 1'b1;
        else                          width_eff = width_ext;
    end

    sgen_edge_det u_edge (
        .clk     (clk),
        .rst     (rst),
        .sync_in (sync_in),
        .rise_o  (rise)
    );

    assign realign    = disc_en & rise;
    assign realign_mf = (disc_rate_e'(disc_rate) == DISC_MULTI);

    sgen_counters #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst        (rst),
        .div_eff    (div_eff),
        .realign    (realign),
        .realign_mf (realign_mf),
        .fcnt_o     (fcnt),
        .mcnt_o     (mcnt)
    );

    sgen_shaper #(.CNT_W(CNT_W)) u_shape (
        .clk       (clk),
        .rst       (rst),
        .pol       (cfg_pol),
        .width_eff (width_eff),
        .fcnt      (fcnt),
        .mcnt      (mcnt),
        .fsync_o   (fsync_o),
        .mfsync_o  (mfsync_o)
    );

    // R3: the clamped width always leaves an idle cycle in the frame
    p_width_clamp_r3: assert property (@(posedge clk) disable iff (rst)
        (width_eff != '0) && (width_eff < div_eff));

endmodule

// File: tb/sim_sync_pulse_gen.sv
module sim_sync_pulse_gen;

    localparam int CNT_W = 16;
    localparam int WID_W = 8;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [CNT_W-1:0] cfg_div = 16'd10;
    logic [WID_W-1:0] cfg_width = 8'd3;
    logic             cfg_pol = 1'b0;
    logic             disc_en = 1'b0;
    logic             disc_rate = 1'b0;
    logic             sync_in = 1'b0;
    logic             fsync_o;
    logic             mfsync_o;

    always #4 clk = ~clk;

    sync_pulse_gen #(.CNT_W(CNT_W), .WID_W(WID_W)) u0 (
        .clk(clk), .rst(rst), .cfg_div(cfg_div), .cfg_width(cfg_width),
        .cfg_pol(cfg_pol), .disc_en(disc_en), .disc_rate(disc_rate),
        .sync_in(sync_in), .fsync_o(fsync_o), .mfsync_o(mfsync_o)
    );

    typedef struct {
        logic  f;
        logic  m;
        string tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_total = 0;
    int   n_fail  = 0;
    int   n_cyc   = 0;
    bit   done    = 0;

    // reference state kept from the requirements
    int   m_fc = 0;
    int   m_mc = 0;
    bit   m_ps = 0;

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    endtask

    // driver: apply one cycle of inputs and queue the expected outputs
    task automatic cyc(input bit r, input bit s, input string tag);
        int   d, w;
        bit   fa, edge_seen;
        exp_t e;
        @(negedge clk);
        rst     = r;
        sync_in = s;
        d = (int'(cfg_div) < 2) ? 2 : int'(cfg_div);
        w = (cfg_width == 0) ? 1 : int'(cfg_width);
        if (w >= d) w = d - 1;
        e.tag = tag;
        if (r) begin
            e.f = cfg_pol; e.m = cfg_pol;
            m_fc = 0; m_mc = 0; m_ps = 0;
        end else begin
            fa  = (m_fc < w);
            e.f = fa ^ cfg_pol;
            e.m = (fa && m_mc == 0) ^ cfg_pol;
            edge_seen = s && !m_ps;
            m_ps = s;
            if (disc_en && edge_seen) begin
                m_fc = 0;
                m_mc = disc_rate ? 0 : (m_mc + 1) % 4;
            end else if (m_fc >= d - 1) begin
                m_fc = 0;
                m_mc = (m_mc + 1) % 4;
            end else begin
                m_fc++;
            end
        end
        @(posedge clk);
        #1;
        exp_q.push_back(e);
    endtask

    task automatic run(input int n, input string tag);
        for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, tag);
    endtask

    task automatic do_reset(input string tag);
        for (int i = 0; i < 3; i++) cyc(1'b1, 1'b0, tag);
    endtask

    // sync pulses of one cycle at an offset to the natural phase
    task automatic run_sync(input int n, input int per, input int off, input string tag);
        for (int i = 0; i < n; i++) cyc(1'b0, (i % per) == off, tag);
    endtask

    // monitor: compare outputs after each edge
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            n_total++;
            if (fsync_o !== e.f || mfsync_o !== e.m) begin
                n_fail++;
                $display("FAIL %s at cycle %0d: actual f=%b m=%b expected f=%b m=%b",
                         e.tag, n_cyc, fsync_o, mfsync_o, e.f, e.m);
            end
        end
    end

    always @(posedge clk) begin
        n_cyc++;
        if (n_cyc > 150000 && !done) begin
            done = 1;
            n_total++;
            n_fail++;
            $display("FAIL watchdog (all R tags): actual=hung expected=finished");
            finish_run();
        end
    end

    initial begin
        // R5 reset level, then R1 / R2 free running
        do_reset("R5 reset idle");
        run(80, "R1 R2 free run");
        // R3 width zero and oversize
        cfg_width = 8'd0;   run(30, "R3 width zero");
        cfg_width = 8'd200; run(30, "R3 width clamp");
        cfg_width = 8'd4;
        // R4 inverted polarity, with R5 idle-high reset
        cfg_pol = 1'b1;
        do_reset("R5 reset idle high");
        run(50, "R4 active low");
        cfg_pol = 1'b0;
        do_reset("R5 reset idle low");
        // R6 frame-rate discipline, pulses off the natural phase
        disc_en = 1'b1; disc_rate = 1'b0;
        run_sync(90, 13, 5, "R6 frame discipline");
        // R7 multiframe-rate discipline
        disc_rate = 1'b1;
        run_sync(90, 29, 7, "R7 multiframe discipline");
        // R8 discipline off, sync ignored
        disc_en = 1'b0;
        run_sync(70, 11, 3, "R8 sync ignored");
        // R9 divide below two
        cfg_div = 16'd1; cfg_width = 8'd5;
        do_reset("R5 reset");
        run(20, "R9 minimum divide");
        cfg_div = 16'd0;
        run(12, "R9 zero divide");
        // R1 nominal 19.44 MHz divide over a full multiframe
        cfg_div = 16'd2430; cfg_width = 8'd8;
        do_reset("R5 reset");
        run(4 * 2430 + 20, "R1 R2 nominal divide");
        repeat (3) @(negedge clk);
        done = 1;
        finish_run();
    end

endmodule